// File: doc/BRIEF.md
# Receive Byte Packer with Word FIFO

This block sits behind a UART byte receiver. It gathers received bytes into a 32-bit word, filling byte lane 0 first, and writes the word into a 16-entry word FIFO (64 bytes in total). A word is written once four bytes have been gathered. A shorter word is written earlier when the receive stream is closed. The stream closes on a receive error, on a byte that equals a programmable match character, on a gap of a set number of bit-times with no new byte, or on a software close request. Each FIFO entry carries a 2-bit count of its valid bytes next to the data.

Software can read the number of bytes still held in the packing register. It can flush the FIFO by holding the flush input high and then releasing it. A mode input lets the RTS output follow the FIFO fill level instead of the UART's own RTS. When the FIFO is full, a new word is discarded and a sticky overflow flag is set.

Top module: `rx_pack_wrap`

## Requirements
- R1: Received bytes are placed in lanes 0,1,2,3 in order (lane n is data bits 8n+7:8n). When the fourth byte arrives, the word is written to the FIFO with count field 0, which means four valid bytes.
- R2: `pending` shows the number of bytes held but not yet written (0 to 3). It rises by one for each byte that does not cause a write, and it returns to 0 whenever a word is written.
- R3: A byte that arrives with `byte_err` high is kept in the word, and the partial word is written at once. Its count field gives the valid bytes, and the lanes above the count read zero.
- R4: When `match_en` is high, a byte equal to `match_char` is kept in the word and the partial word is written at once. When `match_en` is low, that byte is packed like any other.
- R5: When `gap_limit` is non-zero and bytes are pending, the partial word is written on the `gap_limit`-th `bit_tick` after the last byte. Each new byte restarts the count. A `gap_limit` of 0 turns the timeout off.
- R6: A pulse on `sw_close_set` makes `sw_close` read 1. On the next cycle with no incoming byte, any pending bytes are written as a partial word and `sw_close` returns to 0. With nothing pending, nothing is written, but the bit still clears.
- R7: While `flush` is high, the FIFO is emptied, the pending bytes are discarded and `overflow` is cleared.
- R8: When the FIFO holds 16 words, a further word is discarded, the level stays at 16 and `overflow` is set. `overflow` stays set until a flush.
- R9: When `rts_mode` is 1, `rts_n` is 1 (deasserted) while the FIFO holds 8 or more words and 0 otherwise. When `rts_mode` is 0, `rts_n` equals `uart_rts_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | One-cycle strobe for a received byte |
| byte_data | input | 8 | Received byte |
| byte_err | input | 1 | The byte was received with an error |
| match_en | input | 1 | Enables closing on a match character |
| match_char | input | 8 | Character that closes the word |
| bit_tick | input | 1 | One-cycle pulse per bit-time |
| gap_limit | input | 16 | Gap timeout in bit-times, 0 turns it off |
| sw_close_set | input | 1 | Software write of 1 to the close bit |
| flush | input | 1 | FIFO flush level |
| rts_mode | input | 1 | 1: RTS follows the FIFO level |
| uart_rts_n | input | 1 | RTS driven by the UART |
| pop | input | 1 | Removes the head entry |
| sw_close | output | 1 | Close bit readback |
| pending | output | 2 | Bytes held but not yet written |
| pop_word | output | 32 | Head entry data |
| pop_cnt | output | 2 | Head entry valid-byte count (0 means four) |
| fifo_empty | output | 1 | FIFO holds no entry |
| fifo_level | output | 5 | Number of words in the FIFO |
| overflow | output | 1 | Sticky flag: a word was dropped |
| rts_n | output | 1 | RTS output, active low |

## Verification
The assertions assume that `byte_valid` is a single-cycle strobe that never overlaps `flush`, and that `pop` is raised only while the FIFO holds data. The pending-count and level-step properties rely on this. The bench drives every input on the falling clock edge and holds each byte, tick, close and pop strobe for exactly one cycle. It pops only after checking that the FIFO is not empty, and it keeps `flush` apart from byte strobes, so the stimulus stays inside those assumptions.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  localparam int unsigned LANES = 4;
  localparam int unsigned CNT_W = $clog2(LANES);
  typedef struct packed {
    logic [CNT_W-1:0]    cnt;
    logic [LANES*8-1:0]  data;
  } rxw_word_t;
endpackage

// File: rtl/rxw_packer.sv
module rxw_packer
  import rxw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  input  logic             byte_close,
  input  logic             close_req,
  output logic [CNT_W-1:0] pending,
  output logic             push,
  output rxw_word_t        push_word
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LANES - 1);

  logic [LANES*8-1:0] acc_q, acc_n, merged;
  logic [CNT_W-1:0]   cnt_q, cnt_n;

  always_comb begin
    merged = acc_q;
    merged[{cnt_q, 3'b000} +: 8] = byte_data;
  end

  always_comb begin
    acc_n     = acc_q;
    cnt_n     = cnt_q;
    push      = 1'b0;
    push_word = '0;
    if (flush) begin
      acc_n = '0;
      cnt_n = '0;
    end else if (byte_valid) begin
      if (cnt_q == LAST || byte_close) begin
        push           = 1'b1;
        push_word.data = merged;
        push_word.cnt  = cnt_q + 1'b1;
        acc_n          = '0;
        cnt_n          = '0;
      end else begin
        acc_n = merged;
        cnt_n = cnt_q + 1'b1;
      end
    end else if (close_req && cnt_q != '0) begin
      push           = 1'b1;
      push_word.data = acc_q;
      push_word.cnt  = cnt_q;
      acc_n          = '0;
      cnt_n          = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_n;
      cnt_q <= cnt_n;
    end
  end

  assign pending = cnt_q;
endmodule

// File: rtl/rxw_gap_timer.sv
module rxw_gap_timer #(
  parameter int unsigned GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_valid,
  input  logic             armed,
  input  logic             bit_tick,
  input  logic [GAP_W-1:0] gap_limit,
  output logic             fire
);
  logic [GAP_W-1:0] cnt_q, cnt_n;

  assign fire = armed && !byte_valid && bit_tick && (gap_limit != '0) &&
                (cnt_q == gap_limit - 1'b1);

  always_comb begin
    cnt_n = cnt_q;
    if (byte_valid || !armed) cnt_n = '0;
    else if (fire)            cnt_n = '0;
    else if (bit_tick)        cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/rxw_fifo.sv
module rxw_fifo
  import rxw_pkg::*;
#(
  parameter int unsigned DEPTH_W = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH_W),
  localparam int unsigned LVL_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  rxw_word_t        push_word,
  input  logic             pop,
  output rxw_word_t        head,
  output logic             empty,
  output logic [LVL_W-1:0] level,
  output logic             overflow
);
  rxw_word_t        mem [DEPTH_W];
  logic [PTR_W-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [LVL_W-1:0] lvl_q, lvl_n;
  logic             ovf_q, ovf_n;
  logic             full, wr_en, rd_en;

  assign full  = (lvl_q == LVL_W'(DEPTH_W));
  assign empty = (lvl_q == '0);
  assign wr_en = push && !full && !flush;
  assign rd_en = pop && !empty && !flush;

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    lvl_n = lvl_q;
    ovf_n = ovf_q;
    if (flush) begin
      wr_n  = '0;
      rd_n  = '0;
      lvl_n = '0;
      ovf_n = 1'b0;
    end else begin
      if (wr_en) wr_n = (wr_q == PTR_W'(DEPTH_W - 1)) ? '0 : wr_q + 1'b1;
      if (rd_en) rd_n = (rd_q == PTR_W'(DEPTH_W - 1)) ? '0 : rd_q + 1'b1;
      lvl_n = lvl_q + LVL_W'(wr_en) - LVL_W'(rd_en);
      if (push && full) ovf_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      lvl_q <= lvl_n;
      ovf_q <= ovf_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_q] <= push_word;
  end

  assign head     = mem[rd_q];
  assign level    = lvl_q;
  assign overflow = ovf_q;
endmodule

// File: rtl/rx_pack_wrap.sv
module rx_pack_wrap
  import rxw_pkg::*;
#(
  parameter int unsigned DEPTH_W = 16,
  parameter int unsigned GAP_W   = 16,
  localparam int unsigned LVL_W  = $clog2(DEPTH_W) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  input  logic             byte_err,
  input  logic             match_en,
  input  logic [7:0]       match_char,
  input  logic             bit_tick,
  input  logic [GAP_W-1:0] gap_limit,
  input  logic             sw_close_set,
  input  logic             flush,
  input  logic             rts_mode,
  input  logic             uart_rts_n,
  input  logic             pop,
  output logic             sw_close,
  output logic [1:0]       pending,
  output logic [31:0]      pop_word,
  output logic [1:0]       pop_cnt,
  output logic             fifo_empty,
  output logic [LVL_W-1:0] fifo_level,
  output logic             overflow,
  output logic             rts_n
);
  localparam logic [LVL_W-1:0] HALF = LVL_W'(DEPTH_W / 2);

  logic      close_q, close_n;
  logic      match_hit, byte_close, sw_fire, gap_fire, close_req;
  logic      push;
  rxw_word_t push_word, head;

  assign match_hit  = match_en && (byte_data == match_char);
  assign byte_close = byte_err || match_hit;
  assign sw_fire    = close_q && !byte_valid;
  assign close_req  = gap_fire || sw_fire;

  always_comb begin
    close_n = close_q;
    if (sw_close_set) close_n = 1'b1;
    else if (sw_fire) close_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) close_q <= 1'b0;
    else        close_q <= close_n;
  end

  rxw_packer u_pack (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .byte_close (byte_close),
    .close_req  (close_req),
    .pending    (pending),
    .push       (push),
    .push_word  (push_word)
  );

  rxw_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .armed      (pending != 2'd0),
    .bit_tick   (bit_tick),
    .gap_limit  (gap_limit),
    .fire       (gap_fire)
  );

  rxw_fifo #(.DEPTH_W(DEPTH_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (push),
    .push_word (push_word),
    .pop       (pop),
    .head      (head),
    .empty     (fifo_empty),
    .level     (fifo_level),
    .overflow  (overflow)
  );

  assign pop_word = head.data;
  assign pop_cnt  = head.cnt;
  assign sw_close = close_q;
  assign rts_n    = rts_mode ? (fifo_level >= HALF) : uart_rts_n;
endmodule

// File: rtl/rx_pack_wrap_chk.sv
module rx_pack_wrap_chk #(
  parameter int unsigned DEPTH_W = 16,
  parameter int unsigned GAP_W   = 16,
  localparam int unsigned LVL_W  = $clog2(DEPTH_W) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             byte_valid,
  input logic [7:0]       byte_data,
  input logic             byte_err,
  input logic             match_en,
  input logic [7:0]       match_char,
  input logic             sw_close_set,
  input logic             flush,
  input logic             rts_mode,
  input logic             uart_rts_n,
  input logic             pop,
  input logic             sw_close,
  input logic [1:0]       pending,
  input logic             fifo_empty,
  input logic [LVL_W-1:0] fifo_level,
  input logic             overflow,
  input logic             rts_n
);
  logic hit;
  assign hit = match_en && (byte_data == match_char);

  assert_pend_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && !byte_err && !hit && pending != 2'd3 && !flush
    |=> pending == $past(pending) + 2'd1);

  assert_word_push_R1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && pending == 2'd3 && !flush && !pop && fifo_level < LVL_W'(DEPTH_W)
    |=> fifo_level == $past(fifo_level) + 1'b1);

  assert_err_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && byte_err && !flush |=> pending == 2'd0);

  assert_match_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && hit && !flush |=> pending == 2'd0);

  assert_sw_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_close && !byte_valid && !sw_close_set |=> !sw_close && pending == 2'd0);

  assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> fifo_empty && pending == 2'd0 && !overflow);

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !flush |=> overflow);

  assert_level_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LVL_W'(DEPTH_W));

  assert_rts_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rts_mode && fifo_level < LVL_W'(DEPTH_W / 2) |-> !rts_n);

  assert_rts_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rts_mode |-> rts_n == uart_rts_n);
endmodule

bind rx_pack_wrap rx_pack_wrap_chk #(.DEPTH_W(DEPTH_W), .GAP_W(GAP_W)) u_chk (.*);

// File: tb/rx_pack_wrap_test.sv
`timescale 1ns/100ps
module rx_pack_wrap_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        byte_valid, byte_err, match_en, bit_tick, sw_close_set;
  logic        flush, rts_mode, uart_rts_n, pop;
  logic [7:0]  byte_data, match_char;
  logic [15:0] gap_limit;
  logic        sw_close, fifo_empty, overflow, rts_n;
  logic [1:0]  pending, pop_cnt;
  logic [31:0] pop_word;
  logic [4:0]  fifo_level;
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  rx_pack_wrap uut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(logic [7:0] d, logic err);
    @(negedge clk);
    byte_valid = 1'b1; byte_data = d; byte_err = err;
    @(negedge clk);
    byte_valid = 1'b0; byte_err = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
    end
  endtask

  task automatic pop_chk(string tag, logic [31:0] w, logic [1:0] c);
    chk({tag, " nonempty"}, fifo_empty, 1'b0);
    chk({tag, " data"}, pop_word, w);
    chk({tag, " count"}, pop_cnt, c);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic t_reset();
    chk("R2 reset pending", pending, 0);
    chk("R7 reset empty", fifo_empty, 1);
    chk("R8 reset overflow", overflow, 0);
    chk("R6 reset close", sw_close, 0);
    chk("R9 passthrough low", rts_n, 0);
    uart_rts_n = 1'b1;
    #1;
    chk("R9 passthrough high", rts_n, 1);
  endtask

  task automatic t_full_word();
    send(8'h11, 0); chk("R2 pending 1", pending, 1);
    send(8'h22, 0); chk("R2 pending 2", pending, 2);
    send(8'h33, 0); chk("R2 pending 3", pending, 3);
    chk("R1 no early write", fifo_empty, 1);
    send(8'h44, 0); chk("R2 pending wraps", pending, 0);
    pop_chk("R1 full word", 32'h44332211, 2'd0);
  endtask

  task automatic t_error();
    send(8'hA1, 0);
    send(8'hA2, 1);
    chk("R3 pending cleared", pending, 0);
    pop_chk("R3 error word", 32'h0000A2A1, 2'd2);
  endtask

  task automatic t_match();
    match_char = 8'h0D; match_en = 1'b1;
    send(8'h55, 0);
    send(8'h0D, 0);
    pop_chk("R4 match word", 32'h00000D55, 2'd2);
    match_en = 1'b0;
    send(8'h0D, 0);
    chk("R4 disabled keeps byte", pending, 1);
    chk("R4 disabled no write", fifo_empty, 1);
    sw_close_set = 1'b1; @(negedge clk); sw_close_set = 1'b0;
    chk("R6 close bit set", sw_close, 1);
    @(negedge clk);
    chk("R6 close bit cleared", sw_close, 0);
    pop_chk("R6 close word", 32'h0000000D, 2'd1);
  endtask

  task automatic t_gap();
    gap_limit = 16'd3;
    send(8'h77, 0);
    ticks(2);
    chk("R5 before limit", fifo_empty, 1);
    send(8'h78, 0);
    ticks(2);
    chk("R5 restart on byte", pending, 2);
    ticks(1);
    chk("R5 timeout pending", pending, 0);
    pop_chk("R5 timeout word", 32'h00007877, 2'd2);
    gap_limit = 16'd0;
    send(8'h66, 0);
    ticks(6);
    chk("R5 disabled pending", pending, 1);
    chk("R5 disabled no write", fifo_empty, 1);
    sw_close_set = 1'b1; @(negedge clk); sw_close_set = 1'b0;
    @(negedge clk);
    pop_chk("R6 after gap off", 32'h00000066, 2'd1);
  endtask

  task automatic t_empty_close();
    sw_close_set = 1'b1; @(negedge clk); sw_close_set = 1'b0;
    @(negedge clk);
    chk("R6 empty close clears", sw_close, 0);
    chk("R6 empty close no write", fifo_empty, 1);
  endtask

  task automatic t_fill();
    rts_mode = 1'b1;
    uart_rts_n = 1'b0;
    for (int k = 0; k < 16; k++) begin
      for (int j = 0; j < 4; j++) send(8'(k * 4 + j), 0);
      chk("R9 level", fifo_level, k + 1);
      chk("R9 rts by level", rts_n, (k + 1 >= 8) ? 1 : 0);
    end
    chk("R8 no overflow yet", overflow, 0);
    for (int j = 0; j < 4; j++) send(8'hF0 + 8'(j), 0);
    chk("R8 overflow set", overflow, 1);
    chk("R8 level held", fifo_level, 16);
    pop_chk("R8 head intact", 32'h03020100, 2'd0);
    chk("R8 overflow sticky", overflow, 1);
    chk("R8 level after pop", fifo_level, 15);
  endtask

  task automatic t_flush();
    send(8'h99, 0);
    @(negedge clk); flush = 1'b1;
    @(negedge clk);
    chk("R7 flush empty", fifo_empty, 1);
    chk("R7 flush pending", pending, 0);
    chk("R7 flush overflow", overflow, 0);
    chk("R9 rts after flush", rts_n, 0);
    flush = 1'b0;
    for (int j = 0; j < 4; j++) send(8'hC0 + 8'(j), 0);
    pop_chk("R7 after flush", 32'hC3C2C1C0, 2'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog all actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; byte_valid = 0; byte_err = 0; byte_data = 0;
    match_en = 0; match_char = 0; bit_tick = 0; gap_limit = 0;
    sw_close_set = 0; flush = 0; rts_mode = 0; uart_rts_n = 0; pop = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_word();
    t_error();
    t_match();
    t_gap();
    t_empty_close();
    t_fill();
    t_flush();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule